// File: doc/BRIEF.md
# Audio Bus-Master DMA Channel Controller

This block sequences one bus-master audio DMA channel. It walks a circular ring of 32 buffer descriptors in memory. Each descriptor is two 32-bit words: a buffer address and a control word that carries the sample count and two policy flags. The channel keeps three indices. The current index names the descriptor being played. The prefetch index names the one that follows. The last-valid index is set by software and marks where the ring must stop. Software starts the channel through a control register. The channel then fetches descriptors over a request/response read port and counts samples down as an external sample engine hands them over one at a time. When a buffer runs out, the channel raises completion flags.

When the current descriptor is the last valid one, the channel halts. It restarts when software moves the last-valid index forward while the run bit is still set. The status flags are cleared by writing ones to them. Each flag is combined with its own enable to drive a level interrupt.

Top module: `audio_dma_chan`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x01 (only halted set), all three indices and the sample count read 0, `irq` is 0 and `xfer_ready` is 0.
- R2: Control bits: [0] run, [1] register reset, [2] last-valid interrupt enable, [3] FIFO-error interrupt enable, [4] completion interrupt enable. A write with bit 1 clear stores bits 4:0. A write with bit 1 set keeps only bits 4:2 of control, zeroes the three indices and the count, and leaves status at exactly 0x01.
- R3: A control write with run set clears halted, sets prefetch to current+1 and fetches the current descriptor. A control write with run clear sets halted, and no further samples are accepted.
- R4: A descriptor fetch issues two reads, at `bdl_base + 8*index` and then at `bdl_base + 8*index + 4`. The count is loaded from word 1 bits 15:0 with bit 0 forced to 0. Word 0 reads back at address 6 and word 1 at address 7.
- R5: `xfer_ready` is high only when run is set, the channel is not halted, no fetch is in flight, the count is non-zero and buffer completion is clear. Each accepted sample lowers the count by one.
- R6: Status bits: [0] halted, [1] current-equals-last, [2] last-valid completion, [3] buffer completion, [4] FIFO error. When the count reaches zero, bit 1 clears and bit 3 sets if word 1 bit 31 was set. If the current index equals the last-valid index, bits 2, 1 and 0 also set.
- R7: When the count is zero, the channel is running and buffer completion is clear, it advances if the current index is not the last valid one. The current index takes the prefetch value, the prefetch index increments modulo 32, and the new descriptor is fetched. A zero-length descriptor therefore advances without setting flags. At the last valid index the channel halts instead.
- R8: While buffer completion is set, no sample is accepted and the indices do not advance.
- R9: Writing the last-valid index while run is set and the channel is halted clears bits 1 and 0, advances the indices and fetches the new current descriptor. Otherwise the write only stores the index.
- R10: A status write clears each of bits 4:2 that is written as one. Bits 1:0 are unaffected.
- R11: `irq` is (bit 2 AND enable 2) OR (bit 3 AND enable 4) OR (bit 4 AND enable 3), and drops as soon as the flags are cleared.
- R12: A cycle with `fifo_err` high sets status bit 4.
- R13: `underrun_hold` goes high when the last-valid buffer completes with word 1 bit 30 set. It clears on a run write, a last-valid restart or a register reset.
- R14: The read addresses are 0 control, 1 status, 2 last-valid index, 3 current index, 4 prefetch index, 5 count, 6 buffer address and 7 descriptor control word. Writes to addresses 0, 1 and 2 reach control, status and last-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | WD_W (5) | Host write data |
| reg_rdata | output | DATA_W (32) | Host read data (combinational from address) |
| bdl_base | input | ADDR_W (32) | Base address of the descriptor ring |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Descriptor read request accepted |
| mem_req_addr | output | ADDR_W (32) | Descriptor read address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | DATA_W (32) | Read response word |
| xfer_valid | input | 1 | Sample engine offers one sample |
| xfer_ready | output | 1 | Channel accepts a sample |
| fifo_err | input | 1 | FIFO error event |
| irq | output | 1 | Level interrupt |
| underrun_hold | output | 1 | Hold-last-sample policy in force after stop |

## Verification
The assertions assume a well-behaved memory port. Each read request gets exactly one response, after the request handshake and before the next request. No response arrives for a fetch that a register reset has aborted. They also assume `xfer_valid` plays no part while `xfer_ready` is low. The stimulus meets these assumptions. Its memory model answers every accepted request on the following cycle. Register resets are issued only while no fetch is in flight. Samples are offered only in cycles where the channel shows ready.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int CTRL_W = 5;

  localparam int CB_RUN  = 0;
  localparam int CB_RST  = 1;
  localparam int CB_LVIE = 2;
  localparam int CB_FEIE = 3;
  localparam int CB_IOCE = 4;

  localparam int SB_LVBC = 2;
  localparam int SB_BCMP = 3;
  localparam int SB_FERR = 4;

  localparam logic [CTRL_W-1:0] CTRL_KEEP = 5'b11100;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_LAST  = 3'd2,
    RA_CUR   = 3'd3,
    RA_NEXT  = 3'd4,
    RA_CNT   = 3'd5,
    RA_BADDR = 3'd6,
    RA_BCTL  = 3'd7
  } reg_addr_e;

  typedef enum logic [2:0] {
    F_IDLE  = 3'd0,
    F_REQ0  = 3'd1,
    F_WAIT0 = 3'd2,
    F_REQ1  = 3'd3,
    F_WAIT1 = 3'd4
  } fetch_st_e;

  typedef struct packed {
    logic ferr;
    logic bcmp;
    logic lvbc;
    logic celv;
    logic halt;
  } stat_t;
endpackage

// File: rtl/adc_fetch.sv
module adc_fetch import adc_pkg::*; #(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [ADDR_W-1:0] base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] word0,
  output logic [DATA_W-1:0] word1
);
  fetch_st_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] w0_q;
  logic              w0_en;
  logic [ADDR_W-1:0] entry_off;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      F_REQ0:  if (req_ready) st_d = F_WAIT0;
      F_WAIT0: if (rsp_valid) st_d = F_REQ1;
      F_REQ1:  if (req_ready) st_d = F_WAIT1;
      F_WAIT1: if (rsp_valid) st_d = F_IDLE;
      default: st_d = st_q;
    endcase
    if (start) begin
      st_d  = F_REQ0;
      idx_d = start_idx;
    end
    if (abort) st_d = F_IDLE;
  end

  assign w0_en = (st_q == F_WAIT0) && rsp_valid && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= F_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     w0_q <= '0;
    else if (w0_en) w0_q <= rsp_data;
  end

  assign entry_off = ADDR_W'({idx_q, 3'b000});
  assign req_valid = (st_q == F_REQ0) || (st_q == F_REQ1);
  assign req_addr  = base + entry_off + ((st_q == F_REQ1) ? ADDR_W'(4) : '0);
  assign busy      = (st_q != F_IDLE);
  assign done      = (st_q == F_WAIT1) && rsp_valid && !abort;
  assign word0     = w0_q;
  assign word1     = rsp_data;
endmodule

// File: rtl/adc_ring.sv
module adc_ring #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             kick,
  input  logic             adv,
  input  logic             last_we,
  input  logic [IDX_W-1:0] last_d,
  output logic [IDX_W-1:0] cur,
  output logic [IDX_W-1:0] nxt,
  output logic [IDX_W-1:0] last
);
  logic [IDX_W-1:0] cur_q, cur_d, nxt_q, nxt_d, last_q, last_d_int;
  logic             idx_en;

  always_comb begin
    cur_d      = cur_q;
    nxt_d      = nxt_q;
    last_d_int = last_q;
    if (last_we) last_d_int = last_d;
    if (kick) nxt_d = cur_q + 1'b1;
    if (adv) begin
      cur_d = nxt_q;
      nxt_d = nxt_q + 1'b1;
    end
    if (clr) begin
      cur_d      = '0;
      nxt_d      = '0;
      last_d_int = '0;
    end
  end

  assign idx_en = clr || kick || adv || last_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      nxt_q  <= '0;
      last_q <= '0;
    end else if (idx_en) begin
      cur_q  <= cur_d;
      nxt_q  <= nxt_d;
      last_q <= last_d_int;
    end
  end

  assign cur  = cur_q;
  assign nxt  = nxt_q;
  assign last = last_q;
endmodule

// File: rtl/adc_irq.sv
module adc_irq (
  input  logic lvbc,
  input  logic bcmp,
  input  logic ferr,
  input  logic en_lvbc,
  input  logic en_bcmp,
  input  logic en_ferr,
  output logic irq
);
  assign irq = (lvbc & en_lvbc) | (bcmp & en_bcmp) | (ferr & en_ferr);
endmodule

// File: rtl/audio_dma_chan.sv
module audio_dma_chan import adc_pkg::*; #(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  localparam int WD_W  = (IDX_W > CTRL_W) ? IDX_W : CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [WD_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] bdl_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic              fifo_err,
  output logic              irq,
  output logic              underrun_hold
);
  localparam int IOC_BIT = DATA_W - 1;
  localparam int BUP_BIT = DATA_W - 2;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  reg_addr_e         ra;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  stat_t             stat_q, stat_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] baddr_q, bctl_q;
  logic              uhold_q, uhold_d;
  logic              cnt_en;

  logic              wr_ctrl, wr_stat, wr_last;
  logic              ctrl_rst, run_on, run_off, lvi_restart;
  logic              acc, comp, at_last, adv_ok, adv_step, adv_stop;

  logic [IDX_W-1:0]  civ, piv, lvi, f_idx;
  logic              f_start, f_busy, f_done;
  logic [DATA_W-1:0] f_w0, f_w1;

  assign ra      = reg_addr_e'(reg_addr);
  assign wr_ctrl = reg_wr && (ra == RA_CTRL);
  assign wr_stat = reg_wr && (ra == RA_STAT);
  assign wr_last = reg_wr && (ra == RA_LAST);

  assign ctrl_rst    = wr_ctrl &&  reg_wdata[CB_RST];
  assign run_on      = wr_ctrl && !reg_wdata[CB_RST] &&  reg_wdata[CB_RUN];
  assign run_off     = wr_ctrl && !reg_wdata[CB_RST] && !reg_wdata[CB_RUN];
  assign lvi_restart = wr_last && ctrl_q[CB_RUN] && stat_q.halt;

  // Engine activity is held off in any cycle that rewrites control.
  assign xfer_ready = ctrl_q[CB_RUN] && !stat_q.halt && !f_busy &&
                      (cnt_q != '0) && !stat_q.bcmp && !wr_ctrl;
  assign acc        = xfer_valid && xfer_ready;
  assign comp       = acc && (cnt_q == CNT_ONE);
  assign at_last    = (civ == lvi);
  assign adv_ok     = ctrl_q[CB_RUN] && !stat_q.halt && !f_busy &&
                      (cnt_q == '0) && !stat_q.bcmp && !wr_ctrl;
  assign adv_step   = adv_ok && !at_last;
  assign adv_stop   = adv_ok &&  at_last;

  assign f_start = run_on || adv_step || lvi_restart;
  assign f_idx   = run_on ? civ : piv;

  adc_ring #(.IDX_W(IDX_W)) ring_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctrl_rst),
    .kick    (run_on),
    .adv     (adv_step || lvi_restart),
    .last_we (wr_last),
    .last_d  (reg_wdata[IDX_W-1:0]),
    .cur     (civ),
    .nxt     (piv),
    .last    (lvi)
  );

  adc_fetch #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) fetch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (f_start),
    .abort     (ctrl_rst),
    .start_idx (f_idx),
    .base      (bdl_base),
    .req_valid (mem_req_valid),
    .req_ready (mem_req_ready),
    .req_addr  (mem_req_addr),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .busy      (f_busy),
    .done      (f_done),
    .word0     (f_w0),
    .word1     (f_w1)
  );

  adc_irq irq_i (
    .lvbc    (stat_q.lvbc),
    .bcmp    (stat_q.bcmp),
    .ferr    (stat_q.ferr),
    .en_lvbc (ctrl_q[CB_LVIE]),
    .en_bcmp (ctrl_q[CB_IOCE]),
    .en_ferr (ctrl_q[CB_FEIE]),
    .irq     (irq)
  );

  // Control next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_rst)     ctrl_d = ctrl_q & CTRL_KEEP;
    else if (wr_ctrl) ctrl_d = reg_wdata[CTRL_W-1:0];
  end

  // Status next state: host clears first, then events, then host run control
  always_comb begin
    stat_d = stat_q;
    if (wr_stat) begin
      if (reg_wdata[SB_FERR]) stat_d.ferr = 1'b0;
      if (reg_wdata[SB_BCMP]) stat_d.bcmp = 1'b0;
      if (reg_wdata[SB_LVBC]) stat_d.lvbc = 1'b0;
    end
    if (fifo_err) stat_d.ferr = 1'b1;
    if (comp) begin
      stat_d.celv = 1'b0;
      if (bctl_q[IOC_BIT]) stat_d.bcmp = 1'b1;
      if (at_last) begin
        stat_d.lvbc = 1'b1;
        stat_d.halt = 1'b1;
        stat_d.celv = 1'b1;
      end
    end
    if (adv_step) stat_d.celv = 1'b0;
    if (adv_stop) stat_d.halt = 1'b1;
    if (lvi_restart) begin
      stat_d.halt = 1'b0;
      stat_d.celv = 1'b0;
    end
    if (run_on)  stat_d.halt = 1'b0;
    if (run_off) stat_d.halt = 1'b1;
    if (ctrl_rst) stat_d = '{ferr: 1'b0, bcmp: 1'b0, lvbc: 1'b0, celv: 1'b0, halt: 1'b1};
  end

  // Sample count next state
  always_comb begin
    cnt_d = cnt_q;
    if (f_done)   cnt_d = {f_w1[CNT_W-1:1], 1'b0};
    else if (acc) cnt_d = cnt_q - CNT_ONE;
    if (ctrl_rst) cnt_d = '0;
  end
  assign cnt_en = ctrl_rst || f_done || acc;

  // Underrun-policy hold next state
  always_comb begin
    uhold_d = uhold_q;
    if (comp && at_last) uhold_d = bctl_q[BUP_BIT];
    if (run_on || lvi_restart || ctrl_rst) uhold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '{ferr: 1'b0, bcmp: 1'b0, lvbc: 1'b0, celv: 1'b0, halt: 1'b1};
      uhold_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      uhold_q <= uhold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baddr_q <= '0;
      bctl_q  <= '0;
    end else if (f_done) begin
      baddr_q <= f_w0;
      bctl_q  <= f_w1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (ra)
      RA_CTRL:  reg_rdata = DATA_W'(ctrl_q);
      RA_STAT:  reg_rdata = DATA_W'(stat_q);
      RA_LAST:  reg_rdata = DATA_W'(lvi);
      RA_CUR:   reg_rdata = DATA_W'(civ);
      RA_NEXT:  reg_rdata = DATA_W'(piv);
      RA_CNT:   reg_rdata = DATA_W'(cnt_q);
      RA_BADDR: reg_rdata = baddr_q;
      RA_BCTL:  reg_rdata = bctl_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign underrun_hold = uhold_q;
endmodule

// File: rtl/adc_chk.sv
module adc_chk #(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ctrl,
  input logic              halt,
  input logic              bcmp,
  input logic              lvbc,
  input logic              busy,
  input logic              xfer_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [IDX_W-1:0]  civ,
  input logic [IDX_W-1:0]  piv
);
  AST_XFER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ready |-> (!halt && !busy)); // R5

  AST_BCMP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    bcmp |-> !xfer_ready); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n || host_ctrl)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R4

  AST_LAST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvbc) |-> halt); // R6

  AST_CUR_FROM_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(civ) |-> ((civ == $past(piv)) || (civ == '0))); // R7

  AST_NEXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(piv) |-> ((piv == IDX_W'(civ + 1'b1)) || (piv == '0))); // R7
endmodule

bind audio_dma_chan adc_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ctrl  (wr_ctrl),
  .halt       (stat_q.halt),
  .bcmp       (stat_q.bcmp),
  .lvbc       (stat_q.lvbc),
  .busy       (f_busy),
  .xfer_ready (xfer_ready),
  .req_valid  (mem_req_valid),
  .req_ready  (mem_req_ready),
  .req_addr   (mem_req_addr),
  .civ        (civ),
  .piv        (piv)
);

// File: tb/audio_dma_chan_tb_top.sv
module audio_dma_chan_tb_top;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [4:0]  reg_wdata = 5'd0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'd0;
  logic        xfer_valid = 1'b0;
  logic        xfer_ready;
  logic        fifo_err = 1'b0;
  logic        irq;
  logic        underrun_hold;

  int errs = 0;
  int checks = 0;
  logic [31:0] d_w0 [32];
  logic [31:0] d_w1 [32];
  logic [31:0] exp_q [$];
  logic        pend = 1'b0;
  logic [31:0] pend_data = 32'd0;

  always #5 clk = ~clk;

  audio_dma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bdl_base(BASE),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .fifo_err(fifo_err), .irq(irq),
    .underrun_hold(underrun_hold)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lookup(input logic [31:0] a);
    logic [31:0] off = a - BASE;
    return off[2] ? d_w1[off[7:3]] : d_w0[off[7:3]];
  endfunction

  // Driver side of the scoreboard: expected fetch addresses (R4)
  task automatic expect_fetch(input int idx);
    exp_q.push_back(BASE + 32'(idx * 8));
    exp_q.push_back(BASE + 32'(idx * 8 + 4));
  endtask

  // Memory model and monitor: answers one cycle after each request
  always @(negedge clk) begin
    mem_rsp_valid = pend;
    mem_rsp_data  = pend_data;
    pend = 1'b0;
    if (rst_n && mem_req_valid) begin
      pend = 1'b1;
      pend_data = lookup(mem_req_addr);
      if (exp_q.size() == 0) chk("R4 unexpected fetch", mem_req_addr, 32'hFFFF_FFFF);
      else chk("R4 fetch address", mem_req_addr, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [4:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic send(input int n);
    int left = n;
    int guard = 0;
    while (left > 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (xfer_ready) begin xfer_valid = 1'b1; left--; end
      else xfer_valid = 1'b0;
    end
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      d_w0[i] = 32'hA000_0000 + 32'(i * 256);
      d_w1[i] = 32'h0;
    end
    d_w1[0] = 32'h8000_0004;
    d_w1[1] = 32'h0000_0003;
    d_w1[2] = 32'hC000_0002;
    d_w1[3] = 32'h8000_0000;
    d_w1[4] = 32'h0000_0002;

    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd_chk("R1 ctrl", 3'd0, 32'h00);
    rd_chk("R1 status", 3'd1, 32'h01);
    rd_chk("R1 last", 3'd2, 32'h0);
    rd_chk("R1 cur", 3'd3, 32'h0);
    rd_chk("R1 next", 3'd4, 32'h0);
    rd_chk("R1 count", 3'd5, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 xfer_ready", {31'd0, xfer_ready}, 32'd0);

    // R9 last-valid write while stopped only stores
    wr(3'd2, 5'd2);
    rd_chk("R9 stored last", 3'd2, 32'd2);
    rd_chk("R9 still halted", 3'd1, 32'h01);

    // R3 start: fetch descriptor 0
    expect_fetch(0);
    wr(3'd0, 5'h15);
    idle(12);
    rd_chk("R2 ctrl stored", 3'd0, 32'h15);
    rd_chk("R3 halted cleared", 3'd1, 32'h00);
    rd_chk("R3 next = cur+1", 3'd4, 32'd1);
    rd_chk("R4 count load", 3'd5, 32'd4);
    rd_chk("R14 buffer addr", 3'd6, 32'hA000_0000);
    rd_chk("R14 desc control", 3'd7, 32'h8000_0004);

    // R5/R6 four samples with completion request
    send(4);
    idle(3);
    rd_chk("R6 completion flag", 3'd1, 32'h08);
    chk("R11 irq on completion", {31'd0, irq}, 32'd1);
    chk("R8 no ready while flagged", {31'd0, xfer_ready}, 32'd0);
    rd_chk("R5 count zero", 3'd5, 32'd0);
    rd_chk("R8 no advance", 3'd3, 32'd0);

    // R10 clear completion, R7 advance to 1 (odd length masked)
    expect_fetch(1);
    wr(3'd1, 5'h08);
    idle(12);
    chk("R11 irq dropped", {31'd0, irq}, 32'd0);
    rd_chk("R7 cur", 3'd3, 32'd1);
    rd_chk("R7 next", 3'd4, 32'd2);
    rd_chk("R4 bit0 forced low", 3'd5, 32'd2);

    // R7 no completion request: automatic advance to 2
    expect_fetch(2);
    send(2);
    idle(12);
    rd_chk("R7 auto advance", 3'd3, 32'd2);
    rd_chk("R6 no flag without request", 3'd1, 32'h00);

    // R6/R13 last valid buffer with hold policy
    send(2);
    idle(3);
    rd_chk("R6 last completion", 3'd1, 32'h0F);
    chk("R13 hold set", {31'd0, underrun_hold}, 32'd1);
    chk("R5 no ready halted", {31'd0, xfer_ready}, 32'd0);

    // R10 write-one-to-clear, read-only bits untouched
    wr(3'd1, 5'h04);
    rd_chk("R10 clear bit2 only", 3'd1, 32'h0B);
    wr(3'd1, 5'h03);
    rd_chk("R10 read-only unaffected", 3'd1, 32'h0B);
    chk("R11 irq still from bit3", {31'd0, irq}, 32'd1);
    wr(3'd1, 5'h08);
    rd_chk("R10 clear bit3", 3'd1, 32'h03);
    chk("R11 irq low", {31'd0, irq}, 32'd0);

    // R9 restart by last-valid write; zero-length entry 3 skipped (R7)
    expect_fetch(3);
    expect_fetch(4);
    wr(3'd2, 5'd4);
    idle(20);
    rd_chk("R9 restarted status", 3'd1, 32'h00);
    rd_chk("R7 zero length skipped", 3'd3, 32'd4);
    rd_chk("R9 next", 3'd4, 32'd5);
    chk("R13 hold cleared", {31'd0, underrun_hold}, 32'd0);
    send(2);
    idle(3);
    rd_chk("R6 last without request", 3'd1, 32'h07);
    chk("R11 irq last-valid enable", {31'd0, irq}, 32'd1);

    // R12 FIFO error with its enable off then on
    wr(3'd1, 5'h04);
    @(negedge clk); fifo_err = 1'b1;
    @(negedge clk); fifo_err = 1'b0;
    rd_chk("R12 fifo flag", 3'd1, 32'h13);
    chk("R11 fifo masked", {31'd0, irq}, 32'd0);
    expect_fetch(4);
    wr(3'd0, 5'h1D);
    idle(12);
    rd_chk("R3 run again", 3'd1, 32'h12);
    chk("R11 fifo enabled", {31'd0, irq}, 32'd1);
    chk("R5 ready with count", {31'd0, xfer_ready}, 32'd1);

    // R3 run cleared
    wr(3'd0, 5'h1C);
    idle(2);
    rd_chk("R3 halted on stop", 3'd1, 32'h13);
    chk("R3 no ready stopped", {31'd0, xfer_ready}, 32'd0);

    // R2 register reset
    wr(3'd0, 5'h1E);
    idle(2);
    rd_chk("R2 ctrl keeps enables", 3'd0, 32'h1C);
    rd_chk("R2 status", 3'd1, 32'h01);
    rd_chk("R2 last", 3'd2, 32'd0);
    rd_chk("R2 cur", 3'd3, 32'd0);
    rd_chk("R2 next", 3'd4, 32'd0);
    rd_chk("R2 count", 3'd5, 32'd0);
    chk("R2 irq", {31'd0, irq}, 32'd0);

    // R7 full ring walk with modulo-32 wrap
    for (int i = 0; i < 32; i++) d_w1[i] = 32'h0000_0002;
    d_w1[31] = 32'h8000_0002;
    wr(3'd2, 5'd31);
    for (int i = 0; i < 32; i++) expect_fetch(i);
    wr(3'd0, 5'h01);
    @(negedge clk); xfer_valid = 1'b1;
    idle(600);
    xfer_valid = 1'b0;
    idle(2);
    rd_chk("R7 reached last", 3'd3, 32'd31);
    rd_chk("R7 next wrapped", 3'd4, 32'd0);
    rd_chk("R6 final flags", 3'd1, 32'h0F);
    chk("R11 no enables", {31'd0, irq}, 32'd0);
    expect_fetch(0);
    wr(3'd2, 5'd1);
    idle(12);
    rd_chk("R9 wrap restart cur", 3'd3, 32'd0);
    rd_chk("R9 wrap restart next", 3'd4, 32'd1);
    rd_chk("R9 restart keeps sticky flags", 3'd1, 32'h0C);
    chk("R4 all fetches seen", 32'(exp_q.size()), 32'd0);

    finish_run();
  end
endmodule